// File: doc/BRIEF.md
# Split Reference-Clock Timestamp Unit

This block stamps trigger events for a sampling front end. It keeps a running count in the sample clock domain. In plain mode the count is one wide counter that advances on every sample clock. In split mode the count has two fields. The upper field counts active edges of an external reference clock, and the lower field counts sample clocks since the last such edge. Each trigger captures the current count and stores it in a dedicated timestamp FIFO, which is read through a show-ahead read port.

Software sets up the unit through a small write-only register port. Address 0 holds the mode word and address 1 holds the synchronisation timeout. A write to address 2 is a command. A synchronise command arms the unit. The counter is then cleared on the next active reference edge. The wait ends early with a sticky timeout flag if a non-zero limit of sample clocks runs out first. A second mode bit makes an acquisition-start pulse clear the counter, so that stamps are measured from the start of capture.

Top module: `stamp_unit`

## Requirements
- R1: After reset the FIFO is empty and not full, and `syncBusy`, `syncTimeout` and `stampOverflow` are all 0.
- R2: Mode word at address 0 with bits 9 and 10 both clear selects plain mode. The whole count advances by one on every sample clock, and reference edges have no effect on it.
- R3: Mode word bit 9 set selects split mode on rising reference edges. On each such edge the upper HIGH_W bits increment and the lower LOW_W bits return to 0. Between edges the lower field increments once per sample clock.
- R4: Mode word bit 10 set, with bit 9 clear, selects split mode on falling reference edges. Rising edges then leave both fields counting as between edges.
- R5: Writing address 2 with bit 0 set raises `syncBusy` on the next clock. The whole count is cleared when the active reference edge is seen. That edge is the falling edge if bit 10 of the mode word is set and bit 9 is clear, and the rising edge otherwise. Because of the two-stage synchroniser, the clear takes effect on the third sample clock edge after `refClkIn` changes, and `syncBusy` drops on that same edge.
- R6: With a timeout value T > 0 at address 1, a wait that sees no edge ends after T clocks. `syncBusy` falls, `syncTimeout` rises, and the count is left untouched. With T = 0 the wait has no limit. The next synchronise command clears `syncTimeout`.
- R7: When mode word bit 2 is set, a pulse on `acqStart` clears the whole count. When bit 2 is clear, `acqStart` is ignored. Bit 1 (standard mode) means the count is cleared only by command.
- R8: A clock with `trigIn` high writes the count held in that cycle into the FIFO. Entries are read oldest first: `fifoRdData` shows the head entry, and `fifoRdEn` advances to the next one. An empty FIFO stays empty until a trigger arrives.
- R9: A trigger that arrives while `fifoFull` is high is dropped, even if a read happens in the same cycle, and `stampOverflow` is set. The flag stays set until address 2 is written with bit 1 set, and that write does not start a synchronise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 mode, 1 timeout, 2 command |
| regWrData | input | 32 | Register write data |
| acqStart | input | 1 | Acquisition start pulse |
| trigIn | input | 1 | Trigger event, one stamp per high cycle |
| refClkIn | input | 1 | External reference clock, asynchronous |
| fifoRdEn | input | 1 | Pop the head entry of the FIFO |
| fifoRdData | output | LOW_W+HIGH_W | Head entry of the FIFO |
| fifoEmpty | output | 1 | FIFO holds no entry |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH entries |
| syncBusy | output | 1 | Synchronise command waiting for a reference edge |
| syncTimeout | output | 1 | Last synchronise wait ran out of time |
| stampOverflow | output | 1 | Sticky flag: a stamp was dropped |

## Verification
The bench builds the unit with LOW_W = 8, HIGH_W = 8, FIFO_DEPTH = 4 and TO_W = 8. With a four-entry FIFO, five back-to-back triggers are enough to show that an entry is dropped and that the overflow flag stays set. A timeout of six clocks makes the timeout path short enough to count exactly. The 8-bit fields make every expected stamp a small number that can be written down by hand. In that number, the upper byte counts reference edges and the lower byte counts clocks since the last edge.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

  // register addresses
  localparam logic [1:0] ADDR_MODE    = 2'd0;
  localparam logic [1:0] ADDR_TIMEOUT = 2'd1;
  localparam logic [1:0] ADDR_CMD     = 2'd2;

  // mode word bit positions
  localparam int MODE_START_BIT = 2;
  localparam int MODE_RISE_BIT  = 9;
  localparam int MODE_FALL_BIT  = 10;

  // command word bit positions
  localparam int CMD_SYNC_BIT   = 0;
  localparam int CMD_CLROVF_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCount;
    logic refTick;
    logic splitEn;
    logic clearOvf;
  } dpStrobe_t;

  typedef enum logic [0:0] {
    SYNC_IDLE = 1'b0,
    SYNC_WAIT = 1'b1
  } syncState_t;

endpackage

// File: rtl/stamp_fifo.sv
module stamp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  output logic [W-1:0] rdData,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   used;
  logic          doWr, doRd;

  assign empty  = (used == '0);
  assign full   = (used == FULL_CNT);
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
    end
  end

endmodule

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_pkg::*;
#(
  parameter int TO_W        = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic        acqStart,
  input  logic        refClkIn,
  output dpStrobe_t   strobe,
  output logic        syncBusy,
  output logic        syncTimeout
);
  logic            startResetMode, splitRise, splitFall, useFall;
  logic [TO_W-1:0] timeoutLimit, waitCnt;
  logic [SYNC_STAGES:0] refPipe;
  logic            modeWr, toWr, cmdWr, syncReq;
  logic            refRise, refFall, refTick, waitHit, waitExpire;
  syncState_t      state;

  assign modeWr  = regWrEn && (regAddr == ADDR_MODE);
  assign toWr    = regWrEn && (regAddr == ADDR_TIMEOUT);
  assign cmdWr   = regWrEn && (regAddr == ADDR_CMD);
  assign syncReq = cmdWr && regWrData[CMD_SYNC_BIT];

  generate
    if (TO_W < 32) begin : g_unusedHigh
      logic unusedHighBits;
      assign unusedHighBits = ^regWrData[31:TO_W];
    end
  endgenerate

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startResetMode <= 1'b0;
      splitRise      <= 1'b0;
      splitFall      <= 1'b0;
      timeoutLimit   <= '0;
    end else begin
      if (modeWr) begin
        startResetMode <= regWrData[MODE_START_BIT];
        splitRise      <= regWrData[MODE_RISE_BIT];
        splitFall      <= regWrData[MODE_FALL_BIT];
      end
      if (toWr) timeoutLimit <= regWrData[TO_W-1:0];
    end
  end

  // reference clock synchroniser plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refPipe <= '0;
    else        refPipe <= {refPipe[SYNC_STAGES-1:0], refClkIn};
  end

  assign refRise = refPipe[SYNC_STAGES-1] && !refPipe[SYNC_STAGES];
  assign refFall = !refPipe[SYNC_STAGES-1] && refPipe[SYNC_STAGES];
  assign useFall = splitFall && !splitRise;
  assign refTick = useFall ? refFall : refRise;

  assign waitHit    = (state == SYNC_WAIT) && !syncReq && refTick;
  assign waitExpire = (timeoutLimit != '0) && (TO_W'(waitCnt + 1'b1) == timeoutLimit);

  // synchronise command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SYNC_IDLE;
      waitCnt     <= '0;
      syncTimeout <= 1'b0;
    end else if (syncReq) begin
      state       <= SYNC_WAIT;
      waitCnt     <= '0;
      syncTimeout <= 1'b0;
    end else if (state == SYNC_WAIT) begin
      if (refTick) begin
        state <= SYNC_IDLE;
      end else if (waitExpire) begin
        state       <= SYNC_IDLE;
        syncTimeout <= 1'b1;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign syncBusy          = (state == SYNC_WAIT);
  assign strobe.clearCount = waitHit || (startResetMode && acqStart);
  assign strobe.refTick    = refTick;
  assign strobe.splitEn    = splitRise || splitFall;
  assign strobe.clearOvf   = cmdWr && regWrData[CMD_CLROVF_BIT];

endmodule

// File: rtl/stamp_datapath.sv
module stamp_datapath
  import stamp_pkg::*;
#(
  parameter int LOW_W      = 16,
  parameter int HIGH_W     = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = LOW_W + HIGH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic             trigIn,
  input  logic             fifoRdEn,
  output logic [CNT_W-1:0] fifoRdData,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             stampOverflow
);
  logic [HIGH_W-1:0] highCnt;
  logic [LOW_W-1:0]  lowCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      highCnt <= '0;
      lowCnt  <= '0;
    end else if (strobe.clearCount) begin
      highCnt <= '0;
      lowCnt  <= '0;
    end else if (!strobe.splitEn) begin
      {highCnt, lowCnt} <= {highCnt, lowCnt} + 1'b1;
    end else if (strobe.refTick) begin
      highCnt <= highCnt + 1'b1;
      lowCnt  <= '0;
    end else begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  stampOverflow <= 1'b0;
    else if (trigIn && fifoFull) stampOverflow <= 1'b1;
    else if (strobe.clearOvf)    stampOverflow <= 1'b0;
  end

  stamp_fifo #(
    .W     (CNT_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (trigIn),
    .wrData ({highCnt, lowCnt}),
    .rdEn   (fifoRdEn),
    .rdData (fifoRdData),
    .empty  (fifoEmpty),
    .full   (fifoFull)
  );

endmodule

// File: rtl/stamp_unit.sv
module stamp_unit
  import stamp_pkg::*;
#(
  parameter int LOW_W       = 16,
  parameter int HIGH_W      = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int TO_W        = 24,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = LOW_W + HIGH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  input  logic             acqStart,
  input  logic             trigIn,
  input  logic             refClkIn,
  input  logic             fifoRdEn,
  output logic [CNT_W-1:0] fifoRdData,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             syncBusy,
  output logic             syncTimeout,
  output logic             stampOverflow
);
  dpStrobe_t strobe;

  stamp_ctrl #(
    .TO_W        (TO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .acqStart    (acqStart),
    .refClkIn    (refClkIn),
    .strobe      (strobe),
    .syncBusy    (syncBusy),
    .syncTimeout (syncTimeout)
  );

  stamp_datapath #(
    .LOW_W      (LOW_W),
    .HIGH_W     (HIGH_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .trigIn        (trigIn),
    .fifoRdEn      (fifoRdEn),
    .fifoRdData    (fifoRdData),
    .fifoEmpty     (fifoEmpty),
    .fifoFull      (fifoFull),
    .stampOverflow (stampOverflow)
  );

endmodule

// File: rtl/stamp_unit_chk.sv
module stamp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        trigIn,
  input logic        fifoEmpty,
  input logic        fifoFull,
  input logic        syncBusy,
  input logic        syncTimeout,
  input logic        stampOverflow
);
  logic syncCmd, clrCmd;
  assign syncCmd = regWrEn && (regAddr == 2'd2) && regWrData[0];
  assign clrCmd  = regWrEn && (regAddr == 2'd2) && regWrData[1];

  p_sync_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    syncCmd |=> syncBusy);

  p_timeout_ends_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncTimeout) |-> (!syncBusy && $past(syncBusy)));

  p_empty_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoEmpty && !trigIn) |=> fifoEmpty);

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stampOverflow && !clrCmd) |=> stampOverflow);

  p_overflow_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stampOverflow) |-> $past(fifoFull && trigIn));

endmodule

bind stamp_unit stamp_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .regWrEn       (regWrEn),
  .regAddr       (regAddr),
  .regWrData     (regWrData),
  .trigIn        (trigIn),
  .fifoEmpty     (fifoEmpty),
  .fifoFull      (fifoFull),
  .syncBusy      (syncBusy),
  .syncTimeout   (syncTimeout),
  .stampOverflow (stampOverflow)
);

// File: tb/tb_stamp_unit.sv
module tb_stamp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;
  localparam int HW = 8;
  localparam int CW = LW + HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [31:0]   regWrData = '0;
  logic          acqStart = 1'b0;
  logic          trigIn = 1'b0;
  logic          refClkIn = 1'b0;
  logic          fifoRdEn = 1'b0;
  logic [CW-1:0] fifoRdData;
  logic          fifoEmpty, fifoFull, syncBusy, syncTimeout, stampOverflow;

  int   nChecks = 0;
  int   nFails = 0;
  bit   drainOn = 1'b1;
  bit   runDone = 1'b0;
  logic [CW-1:0] expQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  stamp_unit #(
    .LOW_W      (LW),
    .HIGH_W     (HW),
    .FIFO_DEPTH (4),
    .TO_W       (8)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .acqStart      (acqStart),
    .trigIn        (trigIn),
    .refClkIn      (refClkIn),
    .fifoRdEn      (fifoRdEn),
    .fifoRdData    (fifoRdData),
    .fifoEmpty     (fifoEmpty),
    .fifoFull      (fifoFull),
    .syncBusy      (syncBusy),
    .syncTimeout   (syncTimeout),
    .stampOverflow (stampOverflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  // driver: one trigger; the stamp equals the count at this cycle
  task automatic trigPulse(input logic [CW-1:0] expVal, input bit stored);
    if (stored) expQ.push_back(expVal);
    trigIn = 1'b1;
    tick(1);
    trigIn = 1'b0;
  endtask

  // monitor: pops expected stamps as the FIFO presents them (R8)
  initial begin
    forever begin
      @(negedge clk);
      if (drainOn && rst_n && !fifoEmpty) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected stamp", int'(fifoRdData), -1);
        end else begin
          logic [CW-1:0] e;
          e = expQ.pop_front();
          check(fifoRdData == e, "R8 stamp value", int'(fifoRdData), int'(e));
        end
        fifoRdEn = 1'b1;
      end else begin
        fifoRdEn = 1'b0;
      end
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!runDone) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check(fifoEmpty == 1'b1, "R1 empty", fifoEmpty, 1);
    check(fifoFull == 1'b0, "R1 full", fifoFull, 0);
    check({syncBusy, syncTimeout, stampOverflow} == 3'b000, "R1 status",
          {syncBusy, syncTimeout, stampOverflow}, 0);

    // plain mode, synchronise with no time limit (R2, R5, R6)
    regWrite(2'd0, 32'h2);
    regWrite(2'd1, 32'd0);
    regWrite(2'd2, 32'h1);
    check(syncBusy == 1'b1, "R5 busy after command", syncBusy, 1);
    tick(4);
    check(syncBusy == 1'b1, "R6 zero limit keeps waiting", syncBusy, 1);
    refClkIn = 1'b1;
    tick(3);
    check(syncBusy == 1'b0, "R5 busy drops on edge", syncBusy, 0);
    tick(5);
    trigPulse(16'd5, 1'b1);          // R5 cleared at the edge
    refClkIn = 1'b0; tick(3);
    refClkIn = 1'b1; tick(3);
    trigPulse(16'd12, 1'b1);         // R2 reference edges ignored

    // split on rising edges (R3)
    regWrite(2'd0, 32'h202);
    regWrite(2'd2, 32'h1);
    refClkIn = 1'b0; tick(3);
    refClkIn = 1'b1; tick(3);
    check(syncBusy == 1'b0, "R5 split sync done", syncBusy, 0);
    tick(4);
    trigPulse(16'd4, 1'b1);          // R3 low field
    refClkIn = 1'b0; tick(3);
    refClkIn = 1'b1; tick(3);
    tick(2);
    trigPulse(16'h0102, 1'b1);       // R3 high advanced, low restarted

    // split on falling edges (R4)
    regWrite(2'd0, 32'h402);
    regWrite(2'd2, 32'h1);
    refClkIn = 1'b0; tick(3);
    check(syncBusy == 1'b0, "R4 falling edge completes sync", syncBusy, 0);
    tick(3);
    trigPulse(16'd3, 1'b1);          // R4
    refClkIn = 1'b1; tick(3);
    refClkIn = 1'b0; tick(3);
    trigPulse(16'h0100, 1'b1);       // R4 rising ignored, falling counted

    // timeout (R6) and acqStart ignored without start-reset (R7)
    regWrite(2'd0, 32'h202);
    regWrite(2'd1, 32'd6);
    regWrite(2'd2, 32'h1);
    tick(5);
    check(syncBusy == 1'b1, "R6 still waiting", syncBusy, 1);
    check(syncTimeout == 1'b0, "R6 no timeout yet", syncTimeout, 0);
    tick(1);
    check(syncBusy == 1'b0, "R6 wait ended", syncBusy, 0);
    check(syncTimeout == 1'b1, "R6 timeout flag", syncTimeout, 1);
    acqStart = 1'b1; tick(1); acqStart = 1'b0;
    trigPulse(16'h010B, 1'b1);       // R6 count untouched, R7 ignored
    regWrite(2'd2, 32'h1);
    check(syncTimeout == 1'b0, "R6 flag cleared by command", syncTimeout, 0);
    refClkIn = 1'b1; tick(3);

    // start-reset mode (R7)
    regWrite(2'd0, 32'h204);
    tick(2);
    acqStart = 1'b1; tick(1); acqStart = 1'b0;
    tick(3);
    trigPulse(16'd3, 1'b1);          // R7 cleared by acqStart

    // FIFO full and overflow (R9)
    tick(3);
    drainOn = 1'b0;
    trigPulse(16'd7, 1'b1);
    trigPulse(16'd8, 1'b1);
    trigPulse(16'd9, 1'b1);
    trigPulse(16'd10, 1'b1);
    check(fifoFull == 1'b1, "R9 full after depth", fifoFull, 1);
    check(stampOverflow == 1'b0, "R9 no overflow yet", stampOverflow, 0);
    trigPulse(16'd11, 1'b0);
    check(stampOverflow == 1'b1, "R9 overflow set", stampOverflow, 1);
    drainOn = 1'b1;
    tick(8);
    check(fifoEmpty == 1'b1, "R9 dropped stamp absent", fifoEmpty, 1);
    check(expQ.size() == 0, "R9 all stored stamps read", expQ.size(), 0);
    check(stampOverflow == 1'b1, "R9 overflow sticky", stampOverflow, 1);
    regWrite(2'd2, 32'h2);
    check(stampOverflow == 1'b0, "R9 overflow cleared", stampOverflow, 0);
    check(syncBusy == 1'b0, "R9 clear starts no sync", syncBusy, 0);

    runDone = 1'b1;
    finishRun();
  end

endmodule